// File: doc/BRIEF.md
# Serial DAC Frame Receiver

This block is the digital front end of a 16-bit voltage-output converter. A host drives three wires: an active-low frame select, a serial clock and a data line. All three are taken as already synchronised into the system clock. The block finds their edges there. It shifts one data bit in on each falling serial-clock edge of an open frame. When a frame of exactly 24 bits completes, the block commits the frame's payload: a 16-bit conversion code and a 2-bit output-stage mode.

The committed code and mode stay in registers. The mode is decoded into four one-hot controls for the analog output stage: the amplifier drive, a 1k path to ground, a 100k path to ground, and a floating output. Raising the frame select before the last bit cancels the frame. A cancelled frame leaves every register as it was. Each commit and each cancellation raises its own one-cycle strobe.

Top module: `dacfr_top`

## Requirements
- R1: After reset, `dac_code` is 0, `pd_mode` is 00, `amp_en` is 1, `pull_1k`, `pull_100k`, `out_hiz`, `frame_done` and `frame_abort` are 0.
- R2: Frame bits arrive most significant first. Of the 24 bits, bits 23..18 are ignored, bit 17 is the high mode bit, bit 16 is the low mode bit, and bits 15..0 are the code.
- R3: In the first clock cycle after the one that samples the 24th falling `sclk` edge of a frame, `dac_code`, `pd_mode` and the controls show the new frame, and `frame_done` is 1 for exactly that one cycle.
- R4: If `sync_n` rises after fewer than 24 falling `sclk` edges, the code and mode keep their values and `frame_abort` pulses for one cycle. A rise with no open frame gives no pulse.
- R5: Further falling `sclk` edges after the 24th, while `sync_n` stays low, cause no second commit and change nothing.
- R6: A frame opens only on a falling edge of `sync_n`. Falling `sclk` edges while `sync_n` is high, or while it has stayed low since the last commit, are ignored.
- R7: Mode decoding: 00 drives only `amp_en`, 01 only `pull_1k`, 10 only `pull_100k`, 11 only `out_hiz`. Exactly one of the four is high at all times.
- R8: A committed frame with a nonzero mode updates only the mode, and `dac_code` keeps its previous value. A frame with mode 00 loads its code, so returning to normal operation drives the held or newly written code.
- R9: A cancelled frame leaves no residue: the next full frame commits exactly its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame select, active low, synchronised |
| sclk | input | 1 | Serial clock, synchronised |
| din | input | 1 | Serial data, synchronised |
| dac_code | output | 16 | Committed conversion code |
| pd_mode | output | 2 | Committed output-stage mode |
| amp_en | output | 1 | Amplifier drives the output |
| pull_1k | output | 1 | Output tied to ground via 1k |
| pull_100k | output | 1 | Output tied to ground via 100k |
| out_hiz | output | 1 | Output left floating |
| frame_done | output | 1 | One-cycle strobe per committed frame |
| frame_abort | output | 1 | One-cycle strobe per cancelled frame |

## Verification
A serial edge becomes an event in the clock cycle that samples it. The code, the mode, the decoded controls and `frame_done` then change at the next rising clock edge. `frame_abort` changes at the rising edge that first sees `sync_n` high. The bench moves every input on a falling clock edge and reads the outputs on a later falling edge. One rising edge therefore lies between stimulus and check, and the 24th-bit test reads the result exactly one cycle after the last `sclk` fall and reads it again one cycle later. The strobes are counted on every falling clock edge, so a missing or extra commit or cancel shows up as a count mismatch.

// File: rtl/dacfr_pkg.sv
package dacfr_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    PD_NORMAL   = 2'b00,
    PD_GND_1K   = 2'b01,
    PD_GND_100K = 2'b10,
    PD_FLOAT    = 2'b11
  } pd_mode_e;

  localparam int NUM_CTRL = 1 << MODE_W;
endpackage

// File: rtl/dacfr_edge.sv
module dacfr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic sclk,
  output logic sync_fall,
  output logic sync_rise,
  output logic sclk_fall
);
  logic sync_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      sync_q <= sync_n;
      sclk_q <= sclk;
    end
  end

  always_comb begin
    sync_fall = sync_q & ~sync_n;
    sync_rise = ~sync_q & sync_n;
    sclk_fall = sclk_q & ~sclk;
  end
endmodule

// File: rtl/dacfr_shift.sv
module dacfr_shift #(
  parameter int FRAME_W = 24,
  parameter int PAY_W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic             din,
  input  logic             sync_fall,
  input  logic             sync_rise,
  input  logic             sclk_fall,
  output logic             commit,
  output logic             cancel,
  output logic [PAY_W-1:0] payload
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic                armed_q, armed_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [PAY_W-2:0]    sh_q, sh_d;

  assign payload = {sh_q, din};

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    commit  = 1'b0;
    cancel  = 1'b0;
    if (sync_rise) begin
      cancel  = armed_q;
      armed_d = 1'b0;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (sync_fall) begin
      armed_d = 1'b1;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (armed_q && sclk_fall && !sync_n) begin
      sh_d = payload[PAY_W-2:0];
      if (cnt_q == LAST) begin
        commit  = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end

  AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("bit count past frame end"); // R3
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (cnt_q == '0)) else $error("count while no frame open"); // R6
  AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !armed_q) else $error("frame still open after commit"); // R5
endmodule

// File: rtl/dacfr_regs.sv
module dacfr_regs #(
  parameter int CODE_W = 16,
  parameter int PAY_W  = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit,
  input  logic                          cancel,
  input  logic [PAY_W-1:0]              payload,
  output logic [CODE_W-1:0]             code_q,
  output dacfr_pkg::pd_mode_e           mode_q,
  output logic                          done_q,
  output logic                          abort_q
);
  import dacfr_pkg::*;

  logic [CODE_W-1:0] code_d;
  pd_mode_e          mode_d, mode_in;

  assign mode_in = pd_mode_e'(payload[PAY_W-1:CODE_W]);

  always_comb begin
    code_d = code_q;
    mode_d = mode_q;
    if (commit) begin
      mode_d = mode_in;
      if (mode_in == PD_NORMAL) code_d = payload[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      mode_q  <= PD_NORMAL;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      mode_q  <= mode_d;
      done_q  <= commit;
      abort_q <= cancel;
    end
  end

  AST_CODE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(code_q)) else $error("code moved without commit"); // R4
  AST_MODE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(mode_q)) else $error("mode moved without commit"); // R4
  AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && mode_q != PD_NORMAL) |-> $stable(code_q)) else $error("power-down frame changed code"); // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("two commits in a row"); // R5
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && abort_q)) else $error("commit and cancel together"); // R4
endmodule

// File: rtl/dacfr_outdec.sv
module dacfr_outdec (
  input  dacfr_pkg::pd_mode_e              mode,
  output logic [dacfr_pkg::NUM_CTRL-1:0]   ctrl
);
  import dacfr_pkg::*;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    assign ctrl[i] = (mode == pd_mode_e'(i));
  end
endmodule

// File: rtl/dacfr_top.sv
module dacfr_top #(
  parameter int CODE_W = 16,
  parameter int PAD_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              din,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        pd_mode,
  output logic              amp_en,
  output logic              pull_1k,
  output logic              pull_100k,
  output logic              out_hiz,
  output logic              frame_done,
  output logic              frame_abort
);
  import dacfr_pkg::*;

  localparam int PAY_W   = CODE_W + MODE_W;
  localparam int FRAME_W = PAD_W + PAY_W;

  logic                sync_fall, sync_rise, sclk_fall;
  logic                commit, cancel;
  logic [PAY_W-1:0]    payload;
  pd_mode_e            mode_q;
  logic [NUM_CTRL-1:0] ctrl;

  dacfr_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk),
    .sync_fall(sync_fall), .sync_rise(sync_rise), .sclk_fall(sclk_fall)
  );

  dacfr_shift #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .din(din),
    .sync_fall(sync_fall), .sync_rise(sync_rise), .sclk_fall(sclk_fall),
    .commit(commit), .cancel(cancel), .payload(payload)
  );

  dacfr_regs #(.CODE_W(CODE_W), .PAY_W(PAY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cancel(cancel),
    .payload(payload), .code_q(dac_code), .mode_q(mode_q),
    .done_q(frame_done), .abort_q(frame_abort)
  );

  dacfr_outdec u_dec (.mode(mode_q), .ctrl(ctrl));

  assign pd_mode   = mode_q;
  assign amp_en    = ctrl[PD_NORMAL];
  assign pull_1k   = ctrl[PD_GND_1K];
  assign pull_100k = ctrl[PD_GND_100K];
  assign out_hiz   = ctrl[PD_FLOAT];

  AST_ONE_STAGE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({amp_en, pull_1k, pull_100k, out_hiz}) == 1) else $error("output controls not one-hot"); // R7
  AST_CANCEL_NEEDS_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> $past(sync_n)) else $error("cancel without sync high"); // R4
endmodule

// File: tb/sim_dacfr_top.sv
module sim_dacfr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b0;
  logic din = 1'b0;
  logic [15:0] dac_code;
  logic [1:0]  pd_mode;
  logic amp_en, pull_1k, pull_100k, out_hiz, frame_done, frame_abort;

  int n_run = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_abort = 0;

  always #2 clk = ~clk;

  dacfr_top u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
    .dac_code(dac_code), .pd_mode(pd_mode), .amp_en(amp_en),
    .pull_1k(pull_1k), .pull_100k(pull_100k), .out_hiz(out_hiz),
    .frame_done(frame_done), .frame_abort(frame_abort)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done)  n_done++;
      if (frame_abort) n_abort++;
    end
  end

  // {frame word, expected code, expected mode, expected {amp,1k,100k,hiz}}
  localparam logic [45:0] VEC [0:7] = '{
    {24'h001234, 16'h1234, 2'd0, 4'b1000},
    {24'hFCABCD, 16'hABCD, 2'd0, 4'b1000},
    {24'h015555, 16'hABCD, 2'd1, 4'b0100},
    {24'h020000, 16'hABCD, 2'd2, 4'b0010},
    {24'h03FFFF, 16'hABCD, 2'd3, 4'b0001},
    {24'h008001, 16'h8001, 2'd0, 4'b1000},
    {24'hFFFFFF, 16'h8001, 2'd3, 4'b0001},
    {24'h00FFFF, 16'hFFFF, 2'd0, 4'b1000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din  = w[23-i];
      sclk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic open_frame();
    @(negedge clk); sync_n = 1'b1;
    repeat (2) @(negedge clk);
    sync_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic close_frame();
    @(negedge clk); sync_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_idle_outputs(input string req);
    check(req, {16'h0, dac_code}, 32'h0);
    check(req, {30'h0, pd_mode}, 32'h0);
    check(req, {28'h0, amp_en, pull_1k, pull_100k, out_hiz}, 32'h8);
    check(req, {30'h0, frame_done, frame_abort}, 32'h0);
  endtask

  initial begin
    repeat (80000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int d0, a0;
    repeat (3) @(negedge clk);
    check_idle_outputs("R1 reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle_outputs("R1 after release");

    // Table walk: R2 bit layout, R7 decode, R8 code held in power-down
    for (int k = 0; k < 8; k++) begin
      d0 = n_done;
      open_frame();
      send_bits(VEC[k][45:22], 24);
      close_frame();
      check($sformatf("R2/R8 code vec%0d", k), {16'h0, dac_code}, {16'h0, VEC[k][21:6]});
      check($sformatf("R2 mode vec%0d", k), {30'h0, pd_mode}, {30'h0, VEC[k][5:4]});
      check($sformatf("R7 ctrl vec%0d", k), {28'h0, amp_en, pull_1k, pull_100k, out_hiz}, {28'h0, VEC[k][3:0]});
      check($sformatf("R3 one commit vec%0d", k), n_done - d0, 1);
    end

    // R4: cancel after 10 bits
    d0 = n_done; a0 = n_abort;
    open_frame();
    send_bits(24'h024321, 10);
    close_frame();
    check("R4 code kept", {16'h0, dac_code}, 32'hFFFF);
    check("R4 mode kept", {30'h0, pd_mode}, 32'h0);
    check("R4 abort pulse", n_abort - a0, 1);
    check("R4 no commit", n_done - d0, 0);

    // R9: full frame after a cancel carries only its own bits
    open_frame();
    send_bits(24'h000F0F, 24);
    check("R9 clean frame", {16'h0, dac_code}, 32'h0F0F);

    // R4: sync rise after a completed frame is not a cancel
    a0 = n_abort;
    close_frame();
    check("R4 no abort after commit", n_abort - a0, 0);

    // R5: extra edges after the 24th with sync kept low
    d0 = n_done;
    open_frame();
    send_bits(24'h002222, 24);
    send_bits(24'h003333, 24);
    check("R5 single commit", n_done - d0, 1);
    check("R5 code from first frame", {16'h0, dac_code}, 32'h2222);
    // R6: sync still low since commit, no fresh falling edge
    send_bits(24'h014444, 24);
    check("R6 no frame without sync fall", {30'h0, pd_mode}, 32'h0);
    close_frame();
    // R6: serial clock while sync high
    d0 = n_done;
    send_bits(24'h035555, 24);
    check("R6 ignored while sync high", n_done - d0, 0);
    check("R6 code unchanged", {16'h0, dac_code}, 32'h2222);

    // R3: exact cycle of the commit and one-cycle strobe
    open_frame();
    send_bits(24'h00BEEF, 23);
    @(negedge clk); din = 1'b1; sclk = 1'b1;
    @(negedge clk); @(negedge clk);
    sclk = 1'b0;
    check("R3 not before edge", {16'h0, dac_code}, 32'h2222);
    @(negedge clk);
    check("R3 code on time", {16'h0, dac_code}, 32'hBEEF);
    check("R3 strobe high", {31'h0, frame_done}, 32'h1);
    @(negedge clk);
    check("R3 strobe one cycle", {31'h0, frame_done}, 32'h0);
    close_frame();

    // R1: reset while configured returns to defaults
    open_frame();
    send_bits(24'h037777, 24);
    close_frame();
    check("R7 float mode", {28'h0, amp_en, pull_1k, pull_100k, out_hiz}, 32'h1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check_idle_outputs("R1 re-reset");
    summary();
  end
endmodule